// File: doc/BRIEF.md
# Scan Sequencer with Result Buffer

This block sits between a converter's configuration fields and the converter core. When it gets a start pulse, it works out which channels to convert from a 2-bit scan mode, a channel select, the single-ended or differential setting, and whether the highest channel's pin is used for the reference. It then sends one conversion request at a time. It waits for the converter's done pulse before it sends the next request. Each result is stored in a small buffer together with the index of the channel that produced it.

A host reads the stored results as two bytes per entry. The first byte carries a marker bit, the channel tag, a resolution flag and the top four result bits. The second byte carries the low eight result bits. Entries come out in conversion order. Reading past the last stored entry starts again at the first. A not-acknowledge from the host closes the read, and later byte requests are ignored until a new read is opened.

The watch mode repeats its channel range without end. A new start pulse abandons any sequence in progress and begins the new one.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, `conv_go`, `scan_busy`, `rd_active` and `rd_valid` are all 0.
- R2: Mode 2'b00 converts channels 0, 1, ... up to `cfg_sel` in ascending order and then clears `scan_busy`. Each `conv_go` is a single-cycle pulse, and no further pulse comes before `cdone` answers it.
- R3: Mode 2'b01 converts channel `cfg_sel` eight times in a row.
- R4: Mode 2'b11 converts channel `cfg_sel` once.
- R5: Mode 2'b10 converts 0 up to the top channel, then restarts at channel 0 with no end. `scan_busy` stays 1, and each pass overwrites the buffer from its first entry.
- R6: With `cfg_refpin`=1 and `cfg_diff`=0, the multichannel modes (00 and 10) never request channel 3 and end at channel 2.
- R7: With `cfg_diff`=1, `conv_diff` is 1 on each request. The multichannel modes request only the pair leaders 0 and 2, up to the pair that holds `cfg_sel`. The single-channel modes request `cfg_sel` as given, where an odd value means the reversed polarity of the pair 0/1 or 2/3.
- R8: Results are stored in conversion order, each tagged with the index of the channel whose request it answered.
- R9: An entry is read as two bytes. The first is {1, tag[1:0], 1, data[11:8]} and the second is data[7:0]. Each byte appears on `rd_byte` with `rd_valid`=1 in the second cycle after its `byte_req` is sampled.
- R10: `rd_open` starts reading at the first entry. After the second byte of the last entry stored by the current scan, reading wraps to the first entry.
- R11: `rd_nack` drops `rd_active` on the next edge. While `rd_active` is 0, `byte_req` produces no `rd_valid`.
- R12: `scan_go` in any state abandons the current sequence, including an unanswered request, and clears the stored count. The new sequence's first `conv_go` follows two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Scan mode: 00 range, 01 repeat, 10 watch, 11 once |
| cfg_sel | input | 2 | Channel select / top of range |
| cfg_diff | input | 1 | 1 = differential pairs |
| cfg_refpin | input | 1 | 1 = channel 3 pin serves as reference |
| scan_go | input | 1 | Start (or restart) a sequence |
| conv_go | output | 1 | Conversion request strobe |
| conv_ch | output | 2 | Channel for the request |
| conv_diff | output | 1 | Request is differential |
| cdone | input | 1 | Converter result strobe |
| cdata | input | 12 | Converter result |
| scan_busy | output | 1 | Sequence in progress |
| rd_open | input | 1 | Open a read at the first entry |
| byte_req | input | 1 | Request the next byte |
| rd_nack | input | 1 | Host not-acknowledge, closes the read |
| rd_active | output | 1 | Read open |
| rd_valid | output | 1 | `rd_byte` holds a requested byte |
| rd_byte | output | 8 | Read byte |

## Verification
If the channel cursor or the step goes wrong, the very next `conv_go` carries the wrong `conv_ch`, one or two cycles after the preceding `cdone`. If the write index or the stored count goes wrong, nothing shows at conversion time. It shows only at read-out: as a wrong tag or wrong data in a first byte, or as a wrap that comes one entry too early or too late. The bench therefore reads past the end of every scan. A stuck read phase swaps the marker byte and the low byte straight away, on the first `rd_valid` after `rd_open`.

// File: rtl/scanseq_pkg.sv
`timescale 1ns/1ps
package scanseq_pkg;
  typedef enum logic [1:0] {
    MODE_RANGE  = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_WATCH  = 2'b10,
    MODE_ONCE   = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/scanseq_ctrl.sv
`timescale 1ns/1ps
module scanseq_ctrl import scanseq_pkg::*; #(
  parameter int CH_W   = 2,
  parameter int DATA_W = 12,
  parameter int REPEAT = 8,
  parameter int AW     = 3,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [CH_W-1:0]   cfg_sel,
  input  logic              cfg_diff,
  input  logic              cfg_refpin,
  input  logic              scan_go,
  input  logic              cdone,
  input  logic [DATA_W-1:0] cdata,
  output logic              conv_go,
  output logic [CH_W-1:0]   conv_ch,
  output logic              conv_diff,
  output logic              busy,
  output logic              excl_top,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [CH_W+DATA_W-1:0] wr_data,
  output logic [LEN_W-1:0]  stored
);
  localparam logic [CH_W-1:0] TOP_CH = {CH_W{1'b1}};

  seq_state_e        state;
  logic [CH_W-1:0]   cur, step;
  logic [LEN_W-1:0]  len;
  logic              loop, lat_diff;
  logic [AW-1:0]     wr;

  // sequence plan decoded from the live configuration at start
  logic [CH_W-1:0]   top_se, top_df, p_first, p_step;
  logic [LEN_W-1:0]  p_len;
  logic              p_multi;
  always_comb begin
    top_se = cfg_sel;
    if (cfg_refpin && cfg_sel == TOP_CH) top_se = TOP_CH - CH_W'(1);
    top_df  = {cfg_sel[CH_W-1:1], 1'b0};
    p_multi = (cfg_mode == MODE_RANGE) || (cfg_mode == MODE_WATCH);
    p_first = '0;
    p_step  = '0;
    p_len   = LEN_W'(1);
    if (p_multi) begin
      if (cfg_diff) begin
        p_step = CH_W'(2);
        p_len  = LEN_W'(top_df >> 1) + LEN_W'(1);
      end else begin
        p_step = CH_W'(1);
        p_len  = LEN_W'(top_se) + LEN_W'(1);
      end
    end else begin
      p_first = cfg_sel;
      p_len   = (cfg_mode == MODE_REPEAT) ? LEN_W'(REPEAT) : LEN_W'(1);
    end
  end

  logic [LEN_W-1:0] wr_next;
  logic             at_end;
  assign wr_next = LEN_W'(wr) + LEN_W'(1);
  assign at_end  = (wr_next == len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; conv_go <= 1'b0; conv_ch <= '0; conv_diff <= 1'b0;
      busy <= 1'b0; excl_top <= 1'b0; cur <= '0; step <= '0; len <= '0;
      loop <= 1'b0; lat_diff <= 1'b0; wr <= '0; stored <= '0;
    end else begin
      conv_go <= 1'b0;
      if (scan_go) begin
        state    <= ST_ISSUE;
        busy     <= 1'b1;
        cur      <= p_first;
        step     <= p_step;
        len      <= p_len;
        loop     <= (cfg_mode == MODE_WATCH);
        lat_diff <= cfg_diff;
        excl_top <= p_multi && !cfg_diff && cfg_refpin;
        wr       <= '0;
        stored   <= '0;
      end else begin
        case (state)
          ST_ISSUE: begin
            conv_go   <= 1'b1;
            conv_ch   <= cur;
            conv_diff <= lat_diff;
            state     <= ST_WAIT;
          end
          ST_WAIT: if (cdone) begin
            if (wr_next > stored) stored <= wr_next;
            if (at_end) begin
              if (loop) begin
                wr    <= '0;
                cur   <= '0;
                state <= ST_ISSUE;
              end else begin
                state <= ST_IDLE;
                busy  <= 1'b0;
              end
            end else begin
              wr    <= wr + AW'(1);
              cur   <= cur + step;
              state <= ST_ISSUE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en   = (state == ST_WAIT) && cdone && !scan_go;
  assign wr_addr = wr;
  assign wr_data = {conv_ch, cdata};
endmodule

// File: rtl/scanseq_buf.sv
`timescale 1ns/1ps
module scanseq_buf #(
  parameter int W     = 14,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scanseq_rdout.sv
`timescale 1ns/1ps
module scanseq_rdout #(
  parameter int CH_W   = 2,
  parameter int DATA_W = 12,
  parameter int AW     = 3,
  parameter int LEN_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_open,
  input  logic                   byte_req,
  input  logic                   rd_nack,
  input  logic [LEN_W-1:0]       stored,
  input  logic [CH_W+DATA_W-1:0] entry,
  output logic [AW-1:0]          raddr,
  output logic                   rd_active,
  output logic                   rd_valid,
  output logic [7:0]             rd_byte,
  output logic                   byte_hi
);
  localparam int ENTRY_W = CH_W + DATA_W;

  logic          phase, req_d, ph_d;
  logic [AW-1:0] rptr;
  logic [LEN_W-1:0] rnext;
  assign rnext = LEN_W'(rptr) + LEN_W'(1);
  assign raddr = rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_active <= 1'b0; phase <= 1'b0; rptr <= '0; req_d <= 1'b0;
      ph_d <= 1'b0; rd_valid <= 1'b0; rd_byte <= '0; byte_hi <= 1'b0;
    end else begin
      req_d <= 1'b0;
      if (rd_open) begin
        rd_active <= 1'b1;
        phase     <= 1'b0;
        rptr      <= '0;
      end else if (rd_nack) begin
        rd_active <= 1'b0;
      end else if (byte_req && rd_active) begin
        req_d <= 1'b1;
        ph_d  <= phase;
        phase <= ~phase;
        if (phase) rptr <= (rnext >= stored) ? '0 : rptr + AW'(1);
      end
      rd_valid <= req_d;
      if (req_d) begin
        byte_hi <= !ph_d;
        rd_byte <= ph_d ? entry[7:0]
                        : {1'b1, entry[ENTRY_W-1 -: CH_W], 1'b1, entry[DATA_W-1:8]};
      end
    end
  end
endmodule

// File: rtl/scan_sequencer.sv
`timescale 1ns/1ps
module scan_sequencer #(
  parameter int CH_W   = 2,
  parameter int DATA_W = 12,
  parameter int REPEAT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [CH_W-1:0]   cfg_sel,
  input  logic              cfg_diff,
  input  logic              cfg_refpin,
  input  logic              scan_go,
  output logic              conv_go,
  output logic [CH_W-1:0]   conv_ch,
  output logic              conv_diff,
  input  logic              cdone,
  input  logic [DATA_W-1:0] cdata,
  output logic              scan_busy,
  input  logic              rd_open,
  input  logic              byte_req,
  input  logic              rd_nack,
  output logic              rd_active,
  output logic              rd_valid,
  output logic [7:0]        rd_byte
);
  localparam int NUM_CH  = 1 << CH_W;
  localparam int DEPTH   = (REPEAT > NUM_CH) ? REPEAT : NUM_CH;
  localparam int AW      = $clog2(DEPTH);
  localparam int LEN_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = CH_W + DATA_W;

  logic               wr_en, excl_top, byte_hi;
  logic [AW-1:0]      wr_addr, raddr;
  logic [ENTRY_W-1:0] wr_data, entry;
  logic [LEN_W-1:0]   stored;

  scanseq_ctrl #(.CH_W(CH_W), .DATA_W(DATA_W), .REPEAT(REPEAT), .AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .cfg_diff(cfg_diff),
    .cfg_refpin(cfg_refpin), .scan_go(scan_go), .cdone(cdone), .cdata(cdata),
    .conv_go(conv_go), .conv_ch(conv_ch), .conv_diff(conv_diff), .busy(scan_busy),
    .excl_top(excl_top), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stored(stored)
  );

  scanseq_buf #(.W(ENTRY_W), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data), .raddr(raddr), .rdata(entry)
  );

  scanseq_rdout #(.CH_W(CH_W), .DATA_W(DATA_W), .AW(AW), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst(rst), .rd_open(rd_open), .byte_req(byte_req), .rd_nack(rd_nack),
    .stored(stored), .entry(entry), .raddr(raddr), .rd_active(rd_active),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .byte_hi(byte_hi)
  );
endmodule

// File: rtl/scanseq_chk.sv
`timescale 1ns/1ps
module scanseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_go,
  input logic [1:0] conv_ch,
  input logic       scan_busy,
  input logic       excl_top,
  input logic       rd_valid,
  input logic       rd_active,
  input logic [7:0] rd_byte,
  input logic       byte_hi
);
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_go |=> !conv_go); // R2

  AST_GO_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
    conv_go |-> scan_busy); // R12

  AST_TOP_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
    (conv_go && excl_top) |-> (conv_ch != 2'd3)); // R6

  AST_CLOSED_SILENT: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_active, 2)); // R11

  AST_HEAD_MARKS: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && byte_hi) |-> (rd_byte[7] && rd_byte[4])); // R9
endmodule

bind scan_sequencer scanseq_chk u_chk (
  .clk(clk), .rst(rst), .conv_go(conv_go), .conv_ch(conv_ch), .scan_busy(scan_busy),
  .excl_top(excl_top), .rd_valid(rd_valid), .rd_active(rd_active), .rd_byte(rd_byte),
  .byte_hi(byte_hi)
);

// File: tb/tb_scan_sequencer.sv
`timescale 1ns/1ps
module tb_scan_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mode = 2'b00, cfg_sel = 2'b00;
  logic cfg_diff = 1'b0, cfg_refpin = 1'b0, scan_go = 1'b0;
  logic cdone = 1'b0;
  logic [11:0] cdata = '0;
  logic rd_open = 1'b0, byte_req = 1'b0, rd_nack = 1'b0;
  logic conv_go, conv_diff, scan_busy, rd_active, rd_valid;
  logic [1:0] conv_ch;
  logic [7:0] rd_byte;

  always #2.5 clk = ~clk;

  scan_sequencer dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_sel(cfg_sel), .cfg_diff(cfg_diff),
    .cfg_refpin(cfg_refpin), .scan_go(scan_go), .conv_go(conv_go), .conv_ch(conv_ch),
    .conv_diff(conv_diff), .cdone(cdone), .cdata(cdata), .scan_busy(scan_busy),
    .rd_open(rd_open), .byte_req(byte_req), .rd_nack(rd_nack), .rd_active(rd_active),
    .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  int total = 0, bad = 0, seed = 1;
  bit finished = 0;
  int exp_q[$];
  int m_ch[8], m_dat[8];
  int m_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one sequence. exp_q holds one pass; watch mode runs `passes` passes
  // and then leaves the next request unanswered.
  task automatic do_scan(input logic [1:0] m, input logic [1:0] s, input logic d,
                         input logic r, input int passes, input string req);
    int n = exp_q.size();
    int done_cnt = 0;
    @(negedge clk);
    cfg_mode = m; cfg_sel = s; cfg_diff = d; cfg_refpin = r; scan_go = 1'b1;
    @(negedge clk);
    scan_go = 1'b0;
    m_cnt = 0;
    for (int p = 0; p < passes; p++) begin
      foreach (exp_q[i]) begin
        int dv;
        int seen = 0;
        for (int t = 0; t < 12 && seen == 0; t++) begin
          if (t > 0) @(negedge clk);
          if (conv_go) seen = 1;
        end
        chk(seen == 1, req, seen, 1);
        chk(conv_ch == 2'(exp_q[i]), req, conv_ch, exp_q[i]);
        chk(conv_diff == d, "R7", conv_diff, d);
        @(negedge clk);
        chk(conv_go == 1'b0, "R2", conv_go, 0);
        @(negedge clk);
        chk(conv_go == 1'b0, "R2", conv_go, 0);
        dv = (seed * 389 + 123) & 12'hFFF;
        seed++;
        cdone = 1'b1; cdata = 12'(dv);
        @(negedge clk);
        cdone = 1'b0;
        m_ch[done_cnt % n] = exp_q[i];
        m_dat[done_cnt % n] = dv;
        done_cnt++;
        m_cnt = (done_cnt < n) ? done_cnt : n;
      end
    end
    if (m == 2'b10) begin
      int seen = 0;
      chk(scan_busy == 1'b1, "R5", scan_busy, 1);
      for (int t = 0; t < 12 && seen == 0; t++) begin
        @(negedge clk);
        if (conv_go) seen = 1;
      end
      chk(seen == 1 && conv_ch == 2'(exp_q[0]), "R5", conv_ch, exp_q[0]);
    end else begin
      chk(scan_busy == 1'b0, "R2", scan_busy, 0);
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); byte_req = 1'b1;
    @(negedge clk); byte_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_words(input int nw, input string req);
    @(negedge clk); rd_open = 1'b1;
    @(negedge clk); rd_open = 1'b0;
    chk(rd_active == 1'b1, "R10", rd_active, 1);
    for (int j = 0; j < 2 * nw; j++) begin
      int k = (j / 2) % m_cnt;
      int e = (j % 2 == 0) ? (8'h90 | (m_ch[k] << 5) | (m_dat[k] >> 8)) : (m_dat[k] & 8'hFF);
      byte_req = 1'b1;
      @(negedge clk); byte_req = 1'b0;
      @(negedge clk);
      chk(rd_valid == 1'b1, "R9", rd_valid, 1);
      chk(rd_byte == 8'(e), req, rd_byte, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(conv_go == 0 && scan_busy == 0, "R1", {conv_go, scan_busy}, 0);
    chk(rd_active == 0 && rd_valid == 0, "R1", {rd_active, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(conv_go == 0 && scan_busy == 0 && rd_valid == 0, "R1", {conv_go, scan_busy, rd_valid}, 0);

    // R2 R8 R10: full range single-ended, read past the end
    exp_q = '{0, 1, 2, 3};
    do_scan(2'b00, 2'd3, 1'b0, 1'b0, 1, "R2");
    read_words(6, "R8");
    // R6: top channel excluded when its pin is the reference
    exp_q = '{0, 1, 2};
    do_scan(2'b00, 2'd3, 1'b0, 1'b1, 1, "R6");
    read_words(4, "R10");
    // R3: repeat mode, wrap after eight entries
    exp_q = '{2, 2, 2, 2, 2, 2, 2, 2};
    do_scan(2'b01, 2'd2, 1'b0, 1'b0, 1, "R3");
    read_words(9, "R10");
    // R4: once mode on channel 1 (sel 3 with refpin still converts in single mode)
    exp_q = '{1};
    do_scan(2'b11, 2'd1, 1'b0, 1'b0, 1, "R4");
    read_words(2, "R9");
    exp_q = '{3};
    do_scan(2'b11, 2'd3, 1'b0, 1'b1, 1, "R4");
    read_words(1, "R8");
    // R7: differential pair leaders, then reversed polarity single
    exp_q = '{0, 2};
    do_scan(2'b00, 2'd3, 1'b1, 1'b0, 1, "R7");
    read_words(3, "R7");
    exp_q = '{0};
    do_scan(2'b00, 2'd1, 1'b1, 1'b0, 1, "R7");
    exp_q = '{3};
    do_scan(2'b11, 2'd3, 1'b1, 1'b0, 1, "R7");
    // R5 R6: watch mode, two passes with the reference pin in use
    exp_q = '{0, 1, 2};
    do_scan(2'b10, 2'd3, 1'b0, 1'b1, 2, "R5");
    read_words(4, "R5");
    // R12: restart abandons the unanswered request
    exp_q = '{1};
    do_scan(2'b11, 2'd1, 1'b0, 1'b0, 1, "R12");
    read_words(2, "R12");
    // R11: not-acknowledge closes the read
    @(negedge clk); rd_nack = 1'b1;
    @(negedge clk); rd_nack = 1'b0;
    chk(rd_active == 1'b0, "R11", rd_active, 0);
    @(negedge clk); byte_req = 1'b1;
    @(negedge clk); byte_req = 1'b0;
    chk(rd_valid == 1'b0, "R11", rd_valid, 0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R11", rd_valid, 0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R11", rd_valid, 0);
    read_words(1, "R11");
    pulse_req();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule